// File: doc/BRIEF.md
# SAR Converter Control Register Block

This block is the software-facing front end of a successive-approximation converter controller. It sits on a simple 32-bit register bus with separate read and write strobes, and it holds the channel selection, the conversion-complete flag, the captured result, the resolution and overwrite configuration, the repeat-mode and calibration controls, and the calibration failure flag. Writing a channel number starts a conversion. An internal timing engine counts out the conversion time and then captures the converter's code. The interrupt line reports completion.

The analog converter is modelled by the `ana_code` input. The block presents the selected channel on `ana_chan`, and at the end of each conversion window it samples whatever code the stand-in presents. Conversions can be one-shot or repeating. A calibration run can be requested. It occupies a separate counter for a fixed number of cycles and then signals completion through the same flag.

Top module: `sarc_regfile`

## Requirements
- R1: After reset the channel register reads 0x1F with interrupt enable 0. The status, result, configuration, general control and general status registers read 0, and `irq` is low.
- R2: A write to offset 0x00 whose bits [4:0] are not 0x1F starts a conversion on that channel, and bit 7 of the write sets the interrupt enable. CONV_CYCLES cycles later the sampled code is stored in the result register at offset 0x0C, and status bit 0 at offset 0x08 is set.
- R3: A write of channel code 0x1F stops any conversion in progress. No completion follows it.
- R4: `irq` is high exactly while status bit 0 and the interrupt enable are both set.
- R5: A read of offset 0x0C clears status bit 0, unless a completion lands in the same cycle.
- R6: The result is right-justified and masked by configuration bits [3:2] at offset 0x14. Code 0 keeps 8 bits, code 1 keeps 10 bits, and codes 2 and 3 keep 12 bits.
- R7: When configuration bit 16 is 0, a completion that arrives while status bit 0 is still set is discarded. When bit 16 is 1, the new result replaces the old one.
- R8: When general-control bit 6 at offset 0x18 is set, each completion starts the next conversion automatically, until channel code 0x1F is written.
- R9: Writing 1 to general-control bit 7 starts calibration. The bit reads 1 for CAL_CYCLES cycles, then clears itself and sets status bit 0.
- R10: General-status bit 1 at offset 0x1C is set if a conversion is started while calibration runs. It is cleared when the next calibration starts.
- R11: Reads from unmapped or unaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe; read side effects apply at the clock edge |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high, 0 otherwise |
| irq | output | 1 | Completion interrupt |
| ana_chan | output | 5 | Channel currently selected for the converter stand-in |
| ana_code | input | 12 | Code produced by the converter stand-in |

## Verification
The bench builds the block with CONV_CYCLES = 6 and CAL_CYCLES = 10. These short windows let one run cover many back-to-back conversions, repeat mode across several completions, and conversions started inside a calibration window. The ADDR_W default of 8 leaves offsets above the mapped range reachable for the unmapped-access cases. Completion times are known exactly, so the bench can place result reads before, between and after completions. That is how it separates discard from overwrite and read-clear from a new completion.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

   localparam int unsigned RES_W  = 12;
   localparam int unsigned CHAN_W = 5;
   localparam logic [CHAN_W-1:0] CHAN_HALT = 5'h1F;

   localparam int unsigned NUM_REGS  = 6;
   localparam int unsigned IDX_CHAN  = 0;
   localparam int unsigned IDX_STAT  = 1;
   localparam int unsigned IDX_RSLT  = 2;
   localparam int unsigned IDX_CFG   = 3;
   localparam int unsigned IDX_GCTL  = 4;
   localparam int unsigned IDX_GSTAT = 5;

   typedef enum logic [1:0] {
      RES_8   = 2'd0,
      RES_10  = 2'd1,
      RES_12  = 2'd2,
      RES_12B = 2'd3
   } res_mode_t;

   function automatic logic [7:0] reg_offset(input int unsigned idx);
      case (idx)
         IDX_CHAN:  reg_offset = 8'h00;
         IDX_STAT:  reg_offset = 8'h08;
         IDX_RSLT:  reg_offset = 8'h0C;
         IDX_CFG:   reg_offset = 8'h14;
         IDX_GCTL:  reg_offset = 8'h18;
         default:   reg_offset = 8'h1C;
      endcase
   endfunction

   function automatic logic [RES_W-1:0] res_mask(input res_mode_t m,
                                                 input logic [RES_W-1:0] raw);
      case (m)
         RES_8:   res_mask = raw & 12'h0FF;
         RES_10:  res_mask = raw & 12'h3FF;
         default: res_mask = raw;
      endcase
   endfunction

endpackage

// File: rtl/sarc_decode.sv
module sarc_decode
   import sarc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
)(
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] sel
);

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
         localparam logic [7:0] OFS = reg_offset(i);
         if (ADDR_W >= 8) begin : g_wide
            assign sel[i] = (addr == ADDR_W'(OFS));
         end else begin : g_narrow
            assign sel[i] = (addr == OFS[ADDR_W-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/sarc_conv_engine.sv
module sarc_conv_engine #(
   parameter int unsigned CONV_CYCLES = 26
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic halt,
   input  logic repeat_en,
   output logic busy,
   output logic done
);

   localparam int unsigned CNT_W = $clog2(CONV_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done = busy && (cnt_q == '0) && !halt && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (halt) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= LAST;
      end else if (busy) begin
         if (cnt_q == '0) begin
            busy  <= repeat_en;
            cnt_q <= repeat_en ? LAST : '0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sarc_cal_engine.sv
module sarc_cal_engine #(
   parameter int unsigned CAL_CYCLES = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done
);

   localparam int unsigned CNT_W = $clog2(CAL_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end else if (go) begin
         busy  <= 1'b1;
         cnt_q <= LAST;
      end
   end

endmodule

// File: rtl/sarc_regfile.sv
module sarc_regfile
   import sarc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CONV_CYCLES = 26,
   parameter int unsigned CAL_CYCLES  = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic [CHAN_W-1:0] ana_chan,
   input  logic [RES_W-1:0]  ana_code
);

   generate
      if (ADDR_W < 5)       begin : g_bad_addr  $error("ADDR_W must reach offset 0x1C"); end
      if (CONV_CYCLES < 2)  begin : g_bad_conv  $error("CONV_CYCLES must be at least 2"); end
      if (CAL_CYCLES < 2)   begin : g_bad_cal   $error("CAL_CYCLES must be at least 2"); end
   endgenerate

   logic [NUM_REGS-1:0] sel;
   logic [NUM_REGS-1:0] wr_sel;

   logic [CHAN_W-1:0] chan_q;
   logic              ie_q;
   res_mode_t         res_mode_q;
   logic              ovw_q;
   logic              cont_q;
   logic              coco_q;
   logic              calf_q;
   logic [RES_W-1:0]  result_q;

   logic conv_start, conv_halt, conv_busy, conv_done;
   logic cal_go, cal_busy, cal_done;
   logic rslt_rd, capture;

   sarc_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (addr),
      .sel  (sel)
   );

   assign wr_sel     = sel & {NUM_REGS{wr_en}};
   assign conv_start = wr_sel[IDX_CHAN] && (wdata[CHAN_W-1:0] != CHAN_HALT);
   assign conv_halt  = wr_sel[IDX_CHAN] && (wdata[CHAN_W-1:0] == CHAN_HALT);
   assign cal_go     = wr_sel[IDX_GCTL] && wdata[7] && !cal_busy;
   assign rslt_rd    = rd_en && sel[IDX_RSLT];

   sarc_conv_engine #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (conv_start),
      .halt      (conv_halt),
      .repeat_en (cont_q),
      .busy      (conv_busy),
      .done      (conv_done)
   );

   sarc_cal_engine #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (cal_go),
      .busy  (cal_busy),
      .done  (cal_done)
   );

   assign capture = conv_done && (ovw_q || !coco_q);

   // control registers written by the bus
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q     <= CHAN_HALT;
         ie_q       <= 1'b0;
         res_mode_q <= RES_8;
         ovw_q      <= 1'b0;
         cont_q     <= 1'b0;
      end else begin
         if (wr_sel[IDX_CHAN]) begin
            chan_q <= wdata[CHAN_W-1:0];
            ie_q   <= wdata[7];
         end
         if (wr_sel[IDX_CFG]) begin
            res_mode_q <= res_mode_t'(wdata[3:2]);
            ovw_q      <= wdata[16];
         end
         if (wr_sel[IDX_GCTL]) begin
            cont_q <= wdata[6];
         end
      end
   end

   // status, result and calibration flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coco_q   <= 1'b0;
         calf_q   <= 1'b0;
         result_q <= '0;
      end else begin
         if (capture) result_q <= res_mask(res_mode_q, ana_code);

         if (capture || cal_done) coco_q <= 1'b1;
         else if (rslt_rd)        coco_q <= 1'b0;

         if (cal_go)                       calf_q <= 1'b0;
         else if (cal_busy && conv_start)  calf_q <= 1'b1;
      end
   end

   assign irq      = coco_q && ie_q;
   assign ana_chan = chan_q;

   // read mux
   logic [31:0] rd_val [NUM_REGS];

   always_comb begin
      rd_val[IDX_CHAN]  = {24'b0, ie_q, 2'b0, chan_q};
      rd_val[IDX_STAT]  = {31'b0, coco_q};
      rd_val[IDX_RSLT]  = {{(32-RES_W){1'b0}}, result_q};
      rd_val[IDX_CFG]   = {15'b0, ovw_q, 12'b0, res_mode_q, 2'b0};
      rd_val[IDX_GCTL]  = {24'b0, cal_busy, cont_q, 6'b0};
      rd_val[IDX_GSTAT] = {30'b0, calf_q, 1'b0};
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rdata = rdata | rd_val[i];
         end
      end
   end

endmodule

// File: rtl/sarc_checker.sv
module sarc_checker #(
   parameter int unsigned ADDR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata,
   input logic              irq,
   input logic              conv_halt,
   input logic              conv_busy,
   input logic              conv_done,
   input logic              rslt_rd,
   input logic              coco_q,
   input logic              ovw_q,
   input logic [11:0]       result_q,
   input logic [1:0]        res_mode_q,
   input logic              cal_busy,
   input logic              cal_done
);

   p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_halt |=> !conv_busy && !conv_done);

   p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rslt_rd && !conv_done && !cal_done) |=> !irq);

   p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rslt_rd && !conv_done && !cal_done) |=> !coco_q);

   p_mask8_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && res_mode_q == 2'd0) |=> (result_q[11:8] == 4'h0));

   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && coco_q && !ovw_q) |=> $stable(result_q));

   p_cal_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_busy && coco_q);

   p_bad_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[1:0] != 2'b00) |-> (rdata == 32'h0));

endmodule

bind sarc_regfile sarc_checker #(.ADDR_W(ADDR_W)) u_sarc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .addr       (addr),
   .rdata      (rdata),
   .irq        (irq),
   .conv_halt  (conv_halt),
   .conv_busy  (conv_busy),
   .conv_done  (conv_done),
   .rslt_rd    (rslt_rd),
   .coco_q     (coco_q),
   .ovw_q      (ovw_q),
   .result_q   (result_q),
   .res_mode_q (res_mode_q),
   .cal_busy   (cal_busy),
   .cal_done   (cal_done)
);

// File: tb/test_sarc_regfile.sv
module test_sarc_regfile;

   localparam int unsigned ADDR_W = 8;
   localparam int unsigned CONV   = 6;
   localparam int unsigned CAL    = 10;

   localparam logic [7:0] A_CHAN = 8'h00, A_STAT = 8'h08, A_RSLT = 8'h0C,
                          A_CFG  = 8'h14, A_GCTL = 8'h18, A_GST  = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [4:0]  ana_chan;
   logic [11:0] ana_code = '0;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   sarc_regfile #(.ADDR_W(ADDR_W), .CONV_CYCLES(CONV), .CAL_CYCLES(CAL)) i_sarc_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .irq      (irq),
      .ana_chan (ana_chan),
      .ana_code (ana_code)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [11:0] raw;
      logic [11:0] exp;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 12'hABC, 12'h0BC},
      '{2'd1, 12'hABC, 12'h2BC},
      '{2'd2, 12'hABC, 12'hABC},
      '{2'd3, 12'hABC, 12'hABC},
      '{2'd0, 12'hF01, 12'h001},
      '{2'd1, 12'hFFF, 12'h3FF}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      bus_rd(A_CHAN, d); check("R1 chan", d, 32'h1F);
      bus_rd(A_STAT, d); check("R1 stat", d, 32'h0);
      bus_rd(A_RSLT, d); check("R1 rslt", d, 32'h0);
      bus_rd(A_CFG,  d); check("R1 cfg",  d, 32'h0);
      bus_rd(A_GCTL, d); check("R1 gctl", d, 32'h0);
      bus_rd(A_GST,  d); check("R1 gst",  d, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R6 resolution table walk (overwrite on)
      for (int i = 0; i < 6; i++) begin
         bus_wr(A_CFG, 32'h0001_0000 | (32'(VECS[i].mode) << 2));
         ana_code = VECS[i].raw;
         bus_wr(A_CHAN, 32'h05);
         idle(CONV + 2);
         bus_rd(A_STAT, d); check("R2 done flag", d, 32'h1);
         bus_rd(A_RSLT, d); check("R6 masked result", d, {20'b0, VECS[i].exp});
      end
      check("R2 chan out", {27'b0, ana_chan}, 32'h05);

      // R5 read cleared the flag
      bus_rd(A_STAT, d); check("R5 cleared", d, 32'h0);

      // R3 halt mid-conversion
      bus_wr(A_CFG, 32'h0000_0008);
      ana_code = 12'h123;
      bus_wr(A_CHAN, 32'h02);
      idle(2);
      bus_wr(A_CHAN, 32'h1F);
      idle(CONV * 2);
      bus_rd(A_STAT, d); check("R3 no completion", d, 32'h0);

      // R4 interrupt gating
      bus_wr(A_CHAN, 32'h03);
      idle(CONV + 2);
      check("R4 irq off without enable", {31'b0, irq}, 32'h0);
      bus_rd(A_RSLT, d); check("R2 result", d, 32'h123);
      bus_wr(A_CHAN, 32'h83);
      idle(CONV + 2);
      check("R4 irq on", {31'b0, irq}, 32'h1);
      bus_rd(A_RSLT, d);
      idle(1);
      check("R4 irq drops after read", {31'b0, irq}, 32'h0);

      // R7 overwrite disabled: second result discarded
      bus_wr(A_CFG, 32'h0000_0008);
      ana_code = 12'h111;
      bus_wr(A_CHAN, 32'h04);
      idle(CONV + 2);
      ana_code = 12'h222;
      bus_wr(A_CHAN, 32'h04);
      idle(CONV + 2);
      bus_rd(A_RSLT, d); check("R7 discard", d, 32'h111);
      // R7 overwrite enabled: second result replaces
      bus_wr(A_CFG, 32'h0001_0008);
      ana_code = 12'h333;
      bus_wr(A_CHAN, 32'h04);
      idle(CONV + 2);
      ana_code = 12'h444;
      bus_wr(A_CHAN, 32'h04);
      idle(CONV + 2);
      bus_rd(A_RSLT, d); check("R7 overwrite", d, 32'h444);

      // R8 continuous conversion
      bus_wr(A_GCTL, 32'h40);
      ana_code = 12'h055;
      bus_wr(A_CHAN, 32'h06);
      idle(CONV + 2);
      bus_rd(A_RSLT, d); check("R8 first", d, 32'h055);
      ana_code = 12'h0AA;
      idle(CONV + 1);
      bus_rd(A_STAT, d); check("R8 auto restart flag", d, 32'h1);
      bus_rd(A_RSLT, d); check("R8 second", d, 32'h0AA);
      bus_wr(A_CHAN, 32'h1F);
      bus_rd(A_RSLT, d);
      idle(CONV * 3);
      bus_rd(A_STAT, d); check("R8 stops on halt", d, 32'h0);
      bus_wr(A_GCTL, 32'h00);

      // R9 calibration
      bus_wr(A_GCTL, 32'h80);
      bus_rd(A_GCTL, d); check("R9 busy bit", d, 32'h80);
      idle(CAL + 1);
      bus_rd(A_GCTL, d); check("R9 self clear", d, 32'h0);
      bus_rd(A_STAT, d); check("R9 done flag", d, 32'h1);
      bus_rd(A_GST,  d); check("R10 no failure", d, 32'h0);
      bus_rd(A_RSLT, d);

      // R10 conversion during calibration
      bus_wr(A_GCTL, 32'h80);
      bus_wr(A_CHAN, 32'h02);
      idle(CAL + 2);
      bus_rd(A_GST, d); check("R10 failure set", d, 32'h2);
      bus_wr(A_GCTL, 32'h80);
      bus_rd(A_GST, d); check("R10 cleared by new cal", d, 32'h0);
      idle(CAL + 2);
      bus_rd(A_RSLT, d);

      // R11 unmapped and unaligned accesses
      bus_wr(A_CFG, 32'h0000_0004);
      bus_wr(8'h20, 32'hFFFF_FFFF);
      bus_wr(8'h15, 32'h0001_0008);
      bus_wr(8'h02, 32'h0000_0081);
      bus_rd(A_CFG, d);  check("R11 cfg untouched", d, 32'h4);
      bus_rd(A_CHAN, d); check("R11 chan untouched", d, 32'h02);
      bus_rd(8'h20, d);  check("R11 unmapped read", d, 32'h0);
      bus_rd(8'h0D, d);  check("R11 unaligned read", d, 32'h0);
      bus_rd(8'h04, d);  check("R11 gap read", d, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule